// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Receiver

This block decodes remote-control frames that arrive as an already demodulated infrared signal (`ir_in` high while a carrier burst is present). A frame opens with a long leader burst and a long space. Thirty-two data bits follow. Each bit is a short burst followed by a space: a short space stands for 0 and a long space stands for 1. A closing burst ends the frame. A repeat frame has the same leader but a space of about half the length, and it carries no data. The block counts ticks of a 1 MHz timebase (`tick_1us`) between edges of the synchronised input. A state machine classifies each interval. The 32 bits are collected into four byte buffers, and two sticky flags record a complete frame and a repeat. An interrupt line follows those flags.

Four timing thresholds are loaded through one write-only entry port. Each write fills the next threshold in a fixed order and the sequence wraps after the fourth. The thresholds are: leader minimum, data-space minimum, repeat-space minimum and end count. A threshold value of 1 stands for one unit of 2^UNIT_SHIFT ticks (512 by default). The repeat minimum is counted in double units. The end count sets an inactivity timeout: with no edge for that many units, the decoder returns to idle. Software clears the flags with `flag_clr` and reads the bytes at any time.

Top module: `ir_frame_rx`

## Requirements
- R1: After reset, all four byte outputs are 0, and `frame_done`, `repeat_seen` and `irq` are 0.
- R2: Writes on `cfg_wr` fill the thresholds in this order: leader minimum, data-space minimum, repeat minimum, end count. The fifth write wraps back to the leader minimum. The leader minimum is counted in units of 2^UNIT_SHIFT ticks, the data-space minimum in the same units, the repeat minimum in 2^(UNIT_SHIFT+1) ticks, and the end count in 2^UNIT_SHIFT ticks.
- R3: Clearing `enable` returns the write position to the first threshold (leader minimum).
- R4: While `enable` is 0 the decoder stays idle: a complete frame on `ir_in` sets no flag and changes no byte.
- R5: A valid frame fills the bytes LSB first. The first received bit lands in bit 0 of `rx_byte0` and the 32nd in bit 7 of `rx_byte3`. The bytes change only when the 32nd bit is decoded, and at that point `frame_done` is set.
- R6: A bit space within ±25% of BIT0_TICKS decodes as 0, and one within ±25% of BIT1_TICKS decodes as 1. Any other space aborts the frame: no flag is set and the bytes are left unchanged.
- R7: A leader burst shorter than the leader minimum is rejected, and the rest of that frame is ignored.
- R8: A leader space at least the repeat minimum but below the data-space minimum sets `repeat_seen` and leaves the bytes unchanged.
- R9: When no input edge arrives for end-count units, the decoder returns to idle. A frame stalled this way is aborted.
- R10: `irq` is high whenever `frame_done` or `repeat_seen` is high. `flag_clr` clears both flags, but a flag being set in the same cycle takes priority over the clear.
- R11: `inv_ok` is 1 exactly when `rx_byte1` is the bitwise inverse of `rx_byte0` and `rx_byte3` is the inverse of `rx_byte2`.
- R12: The reset thresholds are 0x0E (leader), 0x07 (data space), 0x02 (repeat) and 0x80 (end count).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle timebase strobe, 1 MHz nominal |
| enable | input | 1 | Receiver on; 0 holds decoder idle and resets the write position |
| ir_in | input | 1 | Demodulated infrared input, 1 during a burst |
| cfg_wr | input | 1 | Write strobe for the threshold entry port |
| cfg_data | input | 8 | Threshold value for the next position |
| flag_clr | input | 1 | Clears both flags |
| rx_byte0 | output | 8 | Received bits 0..7 |
| rx_byte1 | output | 8 | Received bits 8..15 |
| rx_byte2 | output | 8 | Received bits 16..23 |
| rx_byte3 | output | 8 | Received bits 24..31 |
| frame_done | output | 1 | Sticky: a full 32-bit frame was received |
| repeat_seen | output | 1 | Sticky: a repeat frame was received |
| inv_ok | output | 1 | Byte pairs are bitwise inverses |
| irq | output | 1 | Interrupt request |

## Verification
Software clearing the flags can fall in the same cycle as the decoder completing a frame. The bench provokes this by holding `flag_clr` high for a whole frame. Since it does not need to know the exact cycle of completion, it then counts the cycles in which `frame_done` and `irq` are high. A correct design shows each high for exactly one cycle, and the bytes hold the new word. A design where the clear wins shows no cycle at all.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

  localparam int CFG_REGS  = 4;
  localparam int CFG_IDX_W = $clog2(CFG_REGS);
  localparam int WORD_BITS = 32;
  localparam int BYTES     = WORD_BITS / 8;

  // Threshold positions, in the order the entry port fills them
  localparam int CFG_LEAD = 0;
  localparam int CFG_DATA = 1;
  localparam int CFG_REP  = 2;
  localparam int CFG_END  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_GAP,
    ST_BURST,
    ST_SPACE,
    ST_TAIL
  } ir_state_e;

  function automatic logic [7:0] cfg_default(input int i);
    case (i)
      CFG_LEAD: cfg_default = 8'h0E;
      CFG_DATA: cfg_default = 8'h07;
      CFG_REP:  cfg_default = 8'h02;
      default:  cfg_default = 8'h80;
    endcase
  endfunction

endpackage

// File: rtl/ir_cfg_regs.sv
module ir_cfg_regs
  import ir_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] thr [CFG_REGS]
);

  logic [CFG_IDX_W-1:0] idx;
  logic [CFG_IDX_W-1:0] slot;

  // While disabled, a write lands on the first position
  assign slot = enable ? idx : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (!enable) idx <= wr ? CFG_IDX_W'(1) : '0;
    else if (wr)     idx <= idx + 1'b1;
  end

  for (genvar g = 0; g < CFG_REGS; g++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             thr[g] <= cfg_default(g);
      else if (wr && slot == CFG_IDX_W'(g))   thr[g] <= wdata;
    end
  end

  // R3: dropping enable without a write parks the position at the start
  p_idx_home_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr) |=> idx == '0);

endmodule

// File: rtl/ir_edge_timer.sv
module ir_edge_timer #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             ir_in,
  output logic             rise,
  output logic             fall,
  output logic [CNT_W-1:0] interval
);

  logic [2:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ir_in};
  end

  assign rise = enable &&  sync_q[1] && !sync_q[2];
  assign fall = enable && !sync_q[1] &&  sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    interval <= '0;
    else if (!enable || rise || fall) interval <= '0;
    else if (tick && !(&interval)) interval <= interval + 1'b1;
  end

endmodule

// File: rtl/ir_frame_fsm.sv
module ir_frame_fsm
  import ir_rx_pkg::*;
#(
  parameter int CNT_W      = 19,
  parameter int UNIT_SHIFT = 9,
  parameter int BIT0_TICKS = 560,
  parameter int BIT1_TICKS = 1690
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 rise,
  input  logic                 fall,
  input  logic [CNT_W-1:0]     interval,
  input  logic [7:0]           thr [CFG_REGS],
  output logic [WORD_BITS-1:0] word,
  output logic                 done_pulse,
  output logic                 rep_pulse
);

  localparam int B0_LO = BIT0_TICKS - BIT0_TICKS / 4;
  localparam int B0_HI = BIT0_TICKS + BIT0_TICKS / 4;
  localparam int B1_LO = BIT1_TICKS - BIT1_TICKS / 4;
  localparam int B1_HI = BIT1_TICKS + BIT1_TICKS / 4;
  localparam int NB_W  = $clog2(WORD_BITS);

  ir_state_e            state;
  logic [NB_W-1:0]      nbits;
  logic [WORD_BITS-1:0] shreg;
  logic [CNT_W-1:0]     lead_lim, data_lim, rep_lim, end_lim;
  logic                 is0, is1;

  assign lead_lim = {{(CNT_W-8){1'b0}}, thr[CFG_LEAD]} << UNIT_SHIFT;
  assign data_lim = {{(CNT_W-8){1'b0}}, thr[CFG_DATA]} << UNIT_SHIFT;
  assign rep_lim  = {{(CNT_W-8){1'b0}}, thr[CFG_REP]}  << (UNIT_SHIFT + 1);
  assign end_lim  = {{(CNT_W-8){1'b0}}, thr[CFG_END]}  << UNIT_SHIFT;

  assign is0 = interval >= CNT_W'(B0_LO) && interval <= CNT_W'(B0_HI);
  assign is1 = interval >= CNT_W'(B1_LO) && interval <= CNT_W'(B1_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      nbits      <= '0;
      shreg      <= '0;
      word       <= '0;
      done_pulse <= 1'b0;
      rep_pulse  <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      rep_pulse  <= 1'b0;
      if (!enable) begin
        state <= ST_IDLE;
        nbits <= '0;
      end else if (state != ST_IDLE && interval >= end_lim) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE:  if (rise) state <= ST_LEAD;
          ST_LEAD:  if (fall) state <= (interval >= lead_lim) ? ST_GAP : ST_IDLE;
          ST_GAP: if (rise) begin
            if (interval >= data_lim) begin
              state <= ST_BURST;
              nbits <= '0;
            end else if (interval >= rep_lim) begin
              state     <= ST_TAIL;
              rep_pulse <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_BURST: if (fall) state <= ST_SPACE;
          ST_SPACE: if (rise) begin
            if (is0 || is1) begin
              shreg <= {is1, shreg[WORD_BITS-1:1]};
              if (nbits == NB_W'(WORD_BITS - 1)) begin
                word       <= {is1, shreg[WORD_BITS-1:1]};
                done_pulse <= 1'b1;
                state      <= ST_TAIL;
              end else begin
                nbits <= nbits + 1'b1;
                state <= ST_BURST;
              end
            end else begin
              state <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4: receiver off forces the idle state
  p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> state == ST_IDLE);

  // R5: the byte buffers move only together with a completion
  p_word_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word) |-> done_pulse);

  // R8: one leader yields either a repeat or a data frame, never both
  p_one_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_pulse, rep_pulse}));

endmodule

// File: rtl/ir_frame_rx.sv
module ir_frame_rx
  import ir_rx_pkg::*;
#(
  parameter int UNIT_SHIFT = 9,
  parameter int BIT0_TICKS = 560,
  parameter int BIT1_TICKS = 1690
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1us,
  input  logic       enable,
  input  logic       ir_in,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_data,
  input  logic       flag_clr,
  output logic [7:0] rx_byte0,
  output logic [7:0] rx_byte1,
  output logic [7:0] rx_byte2,
  output logic [7:0] rx_byte3,
  output logic       frame_done,
  output logic       repeat_seen,
  output logic       inv_ok,
  output logic       irq
);

  localparam int CNT_W = 8 + UNIT_SHIFT + 2;

  logic [7:0]           thr [CFG_REGS];
  logic                 rise, fall;
  logic [CNT_W-1:0]     interval;
  logic [WORD_BITS-1:0] word;
  logic                 done_pulse, rep_pulse;
  logic [7:0]           bytes [BYTES];

  ir_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(enable),
    .wr    (cfg_wr),
    .wdata (cfg_data),
    .thr   (thr)
  );

  ir_edge_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .tick    (tick_1us),
    .ir_in   (ir_in),
    .rise    (rise),
    .fall    (fall),
    .interval(interval)
  );

  ir_frame_fsm #(
    .CNT_W     (CNT_W),
    .UNIT_SHIFT(UNIT_SHIFT),
    .BIT0_TICKS(BIT0_TICKS),
    .BIT1_TICKS(BIT1_TICKS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .rise      (rise),
    .fall      (fall),
    .interval  (interval),
    .thr       (thr),
    .word      (word),
    .done_pulse(done_pulse),
    .rep_pulse (rep_pulse)
  );

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign bytes[b] = word[8*b +: 8];
  end

  assign rx_byte0 = bytes[0];
  assign rx_byte1 = bytes[1];
  assign rx_byte2 = bytes[2];
  assign rx_byte3 = bytes[3];
  assign inv_ok   = (bytes[1] == ~bytes[0]) && (bytes[3] == ~bytes[2]);

  // Set takes priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_done  <= 1'b0;
      repeat_seen <= 1'b0;
    end else begin
      if (done_pulse)    frame_done <= 1'b1;
      else if (flag_clr) frame_done <= 1'b0;
      if (rep_pulse)     repeat_seen <= 1'b1;
      else if (flag_clr) repeat_seen <= 1'b0;
    end
  end

  assign irq = frame_done | repeat_seen;

  // R10: a completion is never lost to a simultaneous clear
  p_done_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> frame_done);

endmodule

// File: tb/ir_frame_rx_bench.sv
module ir_frame_rx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       ir_in = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       flag_clr = 1'b0;
  logic [7:0] rx_byte0, rx_byte1, rx_byte2, rx_byte3;
  logic       frame_done, repeat_seen, inv_ok, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit count_en = 1'b0;
  int done_cycles = 0;
  int irq_cycles = 0;

  localparam logic [31:0] W1 = 32'hC33C_A55A;
  localparam logic [31:0] W2 = 32'h12ED_B748;
  localparam logic [31:0] W3 = 32'h0F0E_0D01;

  always #2.5 clk = ~clk;

  ir_frame_rx #(.UNIT_SHIFT(4), .BIT0_TICKS(40), .BIT1_TICKS(120)) u_ir_frame_rx (
    .clk(clk), .rst_n(rst_n), .tick_1us(1'b1), .enable(enable), .ir_in(ir_in),
    .cfg_wr(cfg_wr), .cfg_data(cfg_data), .flag_clr(flag_clr),
    .rx_byte0(rx_byte0), .rx_byte1(rx_byte1), .rx_byte2(rx_byte2), .rx_byte3(rx_byte3),
    .frame_done(frame_done), .repeat_seen(repeat_seen), .inv_ok(inv_ok), .irq(irq)
  );

  always @(negedge clk) if (count_en) begin
    if (frame_done) done_cycles++;
    if (irq)        irq_cycles++;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bytes_now();
    return {rx_byte3, rx_byte2, rx_byte1, rx_byte0};
  endfunction

  task automatic drive(input logic lvl, input int n);
    ir_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [31:0] w, input int lead, input int gap,
                            input int bad_idx, input int bad_sp, input int stall_idx);
    drive(1'b1, lead);
    drive(1'b0, gap);
    for (int i = 0; i < 32; i++) begin
      drive(1'b1, (i == stall_idx) ? 500 : 40);
      drive(1'b0, (i == bad_idx) ? bad_sp : (w[i] ? 120 : 40));
    end
    drive(1'b1, 40);
    drive(1'b0, 2500);
  endtask

  task automatic send_repeat(input int gap);
    drive(1'b1, 288);
    drive(1'b0, gap);
    drive(1'b1, 40);
    drive(1'b0, 2500);
  endtask

  task automatic cfg_write(input logic [7:0] v);
    cfg_data = v; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "bytes", bytes_now(), 32'h0);
    check("R1", "frame_done", frame_done, 0);
    check("R1", "repeat_seen", repeat_seen, 0);
    check("R1", "irq", irq, 0);
  endtask

  task automatic t_default_frame();
    send_frame(W1, 288, 144, -1, 0, -1);
    check("R5", "bytes LSB first", bytes_now(), W1);
    check("R12", "frame_done with reset thresholds", frame_done, 1);
    check("R10", "irq follows done", irq, 1);
    check("R11", "inv_ok on inverse pairs", inv_ok, 1);
    clear_flags();
    check("R10", "done cleared", frame_done, 0);
    check("R10", "irq cleared", irq, 0);
  endtask

  task automatic t_repeat();
    send_repeat(80);
    check("R8", "repeat_seen", repeat_seen, 1);
    check("R8", "no done on repeat", frame_done, 0);
    check("R8", "bytes kept", bytes_now(), W1);
    clear_flags();
  endtask

  task automatic t_bad_bit();
    send_frame(W2, 288, 144, 5, 70, -1);
    check("R6", "out-of-window bit aborts", frame_done, 0);
    check("R6", "bytes kept", bytes_now(), W1);
    clear_flags();
  endtask

  task automatic t_short_leader();
    send_frame(W2, 150, 144, -1, 0, -1);
    check("R7", "short leader rejected", frame_done, 0);
    check("R7", "bytes kept", bytes_now(), W1);
    clear_flags();
  endtask

  task automatic t_disabled();
    enable = 1'b0;
    send_frame(W2, 288, 144, -1, 0, -1);
    check("R4", "no done while off", frame_done, 0);
    check("R4", "bytes kept while off", bytes_now(), W1);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_config();
    cfg_write(8'h0E); cfg_write(8'h0A); cfg_write(8'h02); cfg_write(8'h18);
    send_frame(W2, 288, 144, -1, 0, -1);
    check("R2", "second write raises data-space min -> repeat", repeat_seen, 1);
    check("R2", "no done", frame_done, 0);
    clear_flags();
    send_frame(W2, 288, 200, -1, 0, 10);
    check("R9", "stalled burst times out", frame_done, 0);
    check("R9", "bytes kept", bytes_now(), W1);
    clear_flags();
    cfg_write(8'h14);
    send_frame(W2, 288, 200, -1, 0, -1);
    check("R2", "fifth write wraps to leader min", frame_done, 0);
    check("R2", "no repeat after wrap", repeat_seen, 0);
    clear_flags();
  endtask

  task automatic t_index_home();
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    cfg_write(8'h0E); cfg_write(8'h07);
    send_frame(W2, 288, 144, -1, 0, -1);
    check("R3", "frame accepted after position reset", frame_done, 1);
    check("R3", "bytes", bytes_now(), W2);
    check("R11", "inv_ok on second word", inv_ok, 1);
    clear_flags();
  endtask

  task automatic t_set_vs_clear();
    done_cycles = 0; irq_cycles = 0;
    flag_clr = 1'b1;
    count_en = 1'b1;
    send_frame(W3, 288, 144, -1, 0, -1);
    count_en = 1'b0;
    flag_clr = 1'b0;
    check("R10", "done seen once despite held clear", done_cycles, 1);
    check("R10", "irq seen once", irq_cycles, 1);
    check("R5", "bytes updated", bytes_now(), W3);
    check("R11", "inv_ok low on non-inverse", inv_ok, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    enable = 1'b1;
    @(negedge clk);
    t_default_frame();
    t_repeat();
    t_bad_bit();
    t_short_leader();
    t_disabled();
    t_config();
    t_index_home();
    t_set_vs_clear();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule